// File: doc/BRIEF.md
# Edge Capture Unit with Two-Entry Timestamp FIFOs

This block timestamps transitions on three independent input pins. Each pin passes through a synchronizer and a qualifier. The qualifier accepts a new level only after it has held for two consecutive rising clock edges, so a one-cycle glitch is dropped. A qualified transition that matches the channel's edge setting pushes the current value of one of two external 16-bit timers into that channel's two-entry FIFO.

Software reaches the block through a simple register port with write enable, read enable, address and 16-bit data. The control register sets the edge mode of each channel, the timer that supplies the time base, and the interrupt enable of each channel. A status register reports the occupancy of each FIFO, including an overflow state. A flag register holds one sticky capture flag per channel, and writing 1 to a flag bit clears it. Reading a FIFO address returns the oldest timestamp and removes it. The interrupt output is high while any flag whose enable is set is high.

Top module: `edge_capture_top`

## Requirements
- R1: A pin change is recognized only after the synchronized level has held for two consecutive rising clock edges. A one-cycle pulse produces no capture. A pulse held for two cycles is captured, and the FIFO holds the new entry four clock edges after the pin changes.
- R2: The edge mode of channel i sits in control bits [2i+1:2i]: 00 off, 01 rising only, 10 falling only, 11 both edges. A transition that the mode excludes changes neither the FIFO nor the flag.
- R3: Control bit 8 picks the time base: 0 stores `timer_a`, 1 stores `timer_b`.
- R4: Each channel FIFO holds two 16-bit entries. Status register (address 1) bits [2i+1:2i] read 00 empty, 01 one entry, 10 two entries, 11 overflow.
- R5: A capture into a full FIFO discards the oldest entry, keeps the newest two in order and sets the status to 11. A later read returns the status to 01.
- R6: A read at address 4+i returns channel i's oldest entry and removes it. A read of an empty FIFO returns 0 and leaves the status at 00.
- R7: Flag register (address 2) bit i is set by every capture on channel i and cleared by writing 1 to that bit. Writing 0 has no effect, and a capture in the same cycle as the clear wins.
- R8: `irq` is high exactly when some flag bit i is set while control bit 9+i is 1.
- R9: The control register (address 0) reads back the last value written. After reset, all registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 3 | Capture pins, one per channel |
| timer_a | input | 16 | First time base |
| timer_b | input | 16 | Second time base |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops a FIFO address) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| irq | output | 1 | Capture interrupt request |

## Verification
Directed patterns cover single-cycle glitches against two-cycle pulses, which tells a working qualifier from a plain synchronizer. Three back-to-back captures show whether the oldest or the newest entry is dropped. Reads of an empty FIFO and a flag clear racing a capture cover the remaining boundaries. Random toggles on random channels, under random edge modes, time-base choices and timer values, are compared against a bench queue model. This shows whether excluded edges are really ignored and whether the wrong timer ever gets stored. Interleaved random reads check pop order and the status encoding.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int TIMER_W  = 16;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 3;
  localparam int TSEL_BIT = 8;
  localparam int IEN_LSB  = 9;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_t;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FIFO0 = 3'd4;

  localparam logic [1:0] ST_EMPTY = 2'b00;
  localparam logic [1:0] ST_ONE   = 2'b01;
  localparam logic [1:0] ST_TWO   = 2'b10;
  localparam logic [1:0] ST_OVF   = 2'b11;
endpackage

// File: rtl/cap_input_qual.sv
module cap_input_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_r, sync_nx;
  logic hold_r, lvl_r, lvl_nx, stable;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_nx = pin;
    end else begin : g_many
      assign sync_nx = {sync_r[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  always_comb begin
    stable = (sync_r[SYNC_STAGES-1] == hold_r);
    lvl_nx = lvl_r;
    if (stable) lvl_nx = sync_r[SYNC_STAGES-1];
    rise = stable &  sync_r[SYNC_STAGES-1] & ~lvl_r;
    fall = stable & ~sync_r[SYNC_STAGES-1] &  lvl_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_r <= '0;
      hold_r <= 1'b0;
      lvl_r  <= 1'b0;
    end else begin
      sync_r <= sync_nx;
      hold_r <= sync_r[SYNC_STAGES-1];
      lvl_r  <= lvl_nx;
    end
  end
endmodule

// File: rtl/cap_fifo2.sv
module cap_fifo2 import cap_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [1:0]   status
);
  logic [W-1:0] e0_r, e1_r, e0_nx, e1_nx;
  logic [1:0]   st_r, st_nx;
  logic         full, en;

  always_comb begin
    full  = (st_r == ST_TWO) || (st_r == ST_OVF);
    e0_nx = e0_r;
    e1_nx = e1_r;
    st_nx = st_r;
    en    = push | pop;
    if (push && pop) begin
      if (st_r == ST_EMPTY) begin
        e0_nx = push_data; st_nx = ST_ONE;
      end else if (st_r == ST_ONE) begin
        e0_nx = push_data;
      end else begin
        e0_nx = e1_r; e1_nx = push_data; st_nx = ST_TWO;
      end
    end else if (push) begin
      if (st_r == ST_EMPTY) begin
        e0_nx = push_data; st_nx = ST_ONE;
      end else if (st_r == ST_ONE) begin
        e1_nx = push_data; st_nx = ST_TWO;
      end else begin
        e0_nx = e1_r; e1_nx = push_data; st_nx = ST_OVF;
      end
    end else if (pop) begin
      if (full) begin
        e0_nx = e1_r; st_nx = ST_ONE;
      end else begin
        st_nx = ST_EMPTY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e0_r <= '0;
      e1_r <= '0;
      st_r <= ST_EMPTY;
    end else if (en) begin
      e0_r <= e0_nx;
      e1_r <= e1_nx;
      st_r <= st_nx;
    end
  end

  assign head   = (st_r == ST_EMPTY) ? '0 : e0_r;
  assign status = st_r;
endmodule

// File: rtl/edge_capture_top.sv
module edge_capture_top import cap_pkg::*; #(
  parameter int NUM_CH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  cap_in,
  input  logic [TIMER_W-1:0] timer_a,
  input  logic [TIMER_W-1:0] timer_b,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic               irq
);
  localparam int ST_W = 2 * NUM_CH;

  logic [REG_W-1:0]   ctrl_r;
  logic [NUM_CH-1:0]  flag_r, flag_nx, push_w, pop_w;
  logic [ST_W-1:0]    fifo_st_w;
  logic [TIMER_W-1:0] head_w [NUM_CH];
  logic [TIMER_W-1:0] tbase;
  logic               flag_wr;

  assign tbase = ctrl_r[TSEL_BIT] ? timer_b : timer_a;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic rise, fall;
      edge_mode_t mode;
      assign mode = edge_mode_t'(ctrl_r[2*gi +: 2]);
      cap_input_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk(clk), .rst_n(rst_n), .pin(cap_in[gi]), .rise(rise), .fall(fall));
      assign push_w[gi] = (rise && (mode == EDGE_RISE || mode == EDGE_BOTH)) ||
                          (fall && (mode == EDGE_FALL || mode == EDGE_BOTH));
      assign pop_w[gi]  = rd_en && (addr == A_FIFO0 + ADDR_W'(gi));
      cap_fifo2 #(.W(TIMER_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_w[gi]), .push_data(tbase),
        .pop(pop_w[gi]), .head(head_w[gi]), .status(fifo_st_w[2*gi +: 2]));
    end
  endgenerate

  always_comb begin
    flag_wr = wr_en && (addr == A_FLAG);
    flag_nx = flag_r;
    if (flag_wr) flag_nx = flag_nx & ~wdata[NUM_CH-1:0];
    flag_nx = flag_nx | push_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_r <= '0;
    else if (wr_en && addr == A_CTRL) ctrl_r <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_r <= '0;
    else if (flag_wr || (|push_w)) flag_r <= flag_nx;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = ctrl_r;
      A_STAT: rdata = {{(REG_W-ST_W){1'b0}}, fifo_st_w};
      A_FLAG: rdata = {{(REG_W-NUM_CH){1'b0}}, flag_r};
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (addr == A_FIFO0 + ADDR_W'(i)) rdata = head_w[i];
      end
    endcase
  end

  assign irq = |(flag_r & ctrl_r[IEN_LSB +: NUM_CH]);
endmodule

// File: rtl/edge_capture_chk.sv
module edge_capture_chk #(
  parameter int NUM_CH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_en,
  input logic [2:0]          addr,
  input logic [15:0]         rdata,
  input logic                irq,
  input logic [2*NUM_CH-1:0] st,
  input logic [NUM_CH-1:0]   push,
  input logic [NUM_CH-1:0]   flags
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_a
      // R4: one capture per cycle, so occupancy climbs at most one step
      p_status_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st[2*gi +: 2]) == 2'b00) |-> (st[2*gi +: 2] != 2'b10 && st[2*gi +: 2] != 2'b11));
      // R5: overflow only reachable from a full FIFO
      p_ovf_from_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st[2*gi +: 2] == 2'b11) |-> ($past(st[2*gi +: 2]) >= 2'b10));
      // R7: a capture always leaves the flag set
      p_push_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push[gi] |=> flags[gi]);
      // R6: empty FIFO reads as zero
      p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'(4 + gi) && st[2*gi +: 2] == 2'b00) |-> (rdata == 16'h0));
    end
  endgenerate
  // R8: no interrupt without a pending flag
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
endmodule

bind edge_capture_top edge_capture_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq(irq), .st(fifo_st_w), .push(push_w), .flags(flag_r));

// File: tb/edge_capture_top_tb.sv
module edge_capture_top_tb;
  localparam int CLK_P = 10;

  logic        clk, rst_n, wr_en, rd_en, irq;
  logic [2:0]  cap_in, addr;
  logic [15:0] timer_a, timer_b, wdata, rdata;

  int n_chk, n_bad;
  logic [15:0] mq [3][2];
  int          mc [3];
  bit          movf [3];
  logic [2:0]  mflag;
  logic [15:0] mctrl;

  edge_capture_top u_dut (.clk(clk), .rst_n(rst_n), .cap_in(cap_in),
    .timer_a(timer_a), .timer_b(timer_b), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic bit edge_hit(logic [1:0] mode, bit rising);
    return rising ? mode[0] : mode[1];
  endfunction

  function automatic logic [1:0] exp_st(int ch);
    return movf[ch] ? 2'b11 : 2'(mc[ch]);
  endfunction

  function automatic logic [5:0] exp_stat_all();
    return {exp_st(2), exp_st(1), exp_st(0)};
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick(1);
    wr_en = 1'b0;
    if (a == 3'd0) mctrl = d;
    if (a == 3'd2) mflag = mflag & ~d[2:0];
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    tick(1);
    rd_en = 1'b0;
  endtask

  task automatic model_push(int ch, logic [15:0] v);
    mflag[ch] = 1'b1;
    if (mc[ch] < 2) begin
      mq[ch][mc[ch]] = v; mc[ch]++;
    end else begin
      mq[ch][0] = mq[ch][1]; mq[ch][1] = v; movf[ch] = 1'b1;
    end
  endtask

  task automatic pop_check(string tag, int ch);
    logic [15:0] d, e;
    e = (mc[ch] == 0) ? 16'h0 : mq[ch][0];
    rd(3'(4 + ch), d);
    check(tag, d, e);
    if (mc[ch] > 0) begin
      mq[ch][0] = mq[ch][1]; mc[ch]--; movf[ch] = 1'b0;
    end
  endtask

  task automatic stat_check(string tag);
    logic [15:0] d;
    rd(3'd1, d);
    check(tag, d, {10'h0, exp_stat_all()});
  endtask

  task automatic toggle(int ch);
    bit rising;
    rising = ~cap_in[ch];
    cap_in[ch] = rising;
    tick(6);
    if (edge_hit(mctrl[2*ch +: 2], rising))
      model_push(ch, mctrl[8] ? timer_b : timer_a);
  endtask

  initial begin
    logic [15:0] d;
    n_chk = 0; n_bad = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cap_in = '0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    timer_a = 16'h1111; timer_b = 16'h2222;
    mflag = '0; mctrl = '0;
    for (int c = 0; c < 3; c++) begin mc[c] = 0; movf[c] = 0; end
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R9 reset state
    rd(3'd0, d); check("R9 ctrl reset", d, 16'h0);
    rd(3'd1, d); check("R9 status reset", d, 16'h0);
    rd(3'd2, d); check("R9 flags reset", d, 16'h0);
    check("R9 irq reset", {15'h0, irq}, 16'h0);
    wr(3'd0, 16'h0A5B); rd(3'd0, d); check("R9 ctrl readback", d, 16'h0A5B);

    // R1 glitch rejected: ch0 both edges
    wr(3'd0, 16'h0003);
    cap_in[0] = 1'b1; tick(1); cap_in[0] = 1'b0; tick(6);
    stat_check("R1 one-cycle glitch ignored");
    // R1 two-cycle pulse captured, entry present after four edges
    timer_a = 16'hABCD;
    cap_in[0] = 1'b1; tick(2); cap_in[0] = 1'b0;
    tick(2);
    model_push(0, 16'hABCD);
    stat_check("R1 capture after four edges");
    tick(6);
    model_push(0, 16'hABCD);
    stat_check("R1 falling edge of pulse");
    pop_check("R6 pop oldest", 0);
    pop_check("R6 pop second", 0);
    pop_check("R6 empty read zero", 0);
    stat_check("R6 empty stays empty");

    // R5 overflow: three captures on ch1 rising+falling, timer_b
    wr(3'd2, 16'h0007);
    wr(3'd0, 16'h010C);
    timer_b = 16'h0001; toggle(1);
    timer_b = 16'h0002; toggle(1);
    timer_b = 16'h0003; toggle(1);
    stat_check("R5 overflow status");
    pop_check("R5 oldest dropped", 1);
    stat_check("R5 status back to one");
    pop_check("R5 newest kept", 1);

    // R2 excluded edge: ch2 rising only, falling must not capture
    wr(3'd0, 16'h0010);
    toggle(2); toggle(2);
    stat_check("R2 falling ignored in rising mode");
    pop_check("R3 timer_a chosen", 2);

    // R7/R8 flags and irq
    rd(3'd2, d); check("R7 flags set", d, {13'h0, mflag});
    check("R8 irq masked", {15'h0, irq}, 16'h0);
    wr(3'd0, 16'h0810);
    check("R8 irq enabled ch2", {15'h0, irq}, 16'h1);
    wr(3'd2, 16'h0000);
    rd(3'd2, d); check("R7 write zero no effect", d, {13'h0, mflag});
    wr(3'd2, 16'h0004);
    rd(3'd2, d); check("R7 write one clears", d, {13'h0, mflag});
    check("R8 irq drops", {15'h0, irq}, {15'h0, |(mflag & mctrl[11:9])});
    // R7 capture wins over a clear in the same cycle: pin change lands on
    // the fourth edge, the clear is issued on that same edge
    cap_in[2] = 1'b0; tick(1);
    cap_in[2] = 1'b1; tick(3);
    wr(3'd2, 16'h0004);
    tick(3);
    model_push(2, 16'h0);
    mq[2][mc[2]-1] = timer_a;
    rd(3'd2, d); check("R7 capture beats clear", d[2], 1'b1);
    pop_check("R7 race entry", 2);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int ch;
      ch = int'($urandom % 3);
      if ($urandom % 8 == 0) wr(3'd0, 16'($urandom) & 16'h0F3F);
      timer_a = 16'($urandom); timer_b = 16'($urandom);
      toggle(ch);
      stat_check("R4 random status");
      if ($urandom % 2 == 0) pop_check("R6 random pop", int'($urandom % 3));
      if ($urandom % 5 == 0) begin
        rd(3'd2, d); check("R7 random flags", d, {13'h0, mflag});
        check("R8 random irq", {15'h0, irq}, {15'h0, |(mflag & mctrl[11:9])});
        wr(3'd2, 16'($urandom % 8));
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule